// File: doc/BRIEF.md
# Awake and Reset Pulse Generator

This block turns wake-up activity into a reset pulse of fixed width for a terminal. It watches an active-low awake request pin, which is used purely as an input. It also watches the 4-bit command/indication code that a serial frame interface delivers with a one-cycle valid strobe. A falling edge on the pin always raises a sticky awake interrupt flag. A configuration bit then decides what may start a reset pulse. In awake mode, a pin falling edge or a change in the received code starts one. In watchdog mode, only the expiry of an internal watchdog timer starts one.

The watchdog is a down-counter that software keeps alive with a service strobe. When it runs out it reloads by itself, sets a timer-status flag and, in watchdog mode, starts a reset pulse. The timer-status flag is cleared by nothing but the hardware reset input. The reset pulse it helps produce does not clear it, and neither does any strobe.

The code input has a valid strobe but no ready. The block never applies back-pressure: every cycle with valid high delivers one code, and that code is compared and stored in the same cycle.

Top module: `awake_rst_gen`

## Requirements
- R1: While the hardware reset is active, and right after it, the reset pulse, the awake interrupt flag and the timer-status flag are 0. The stored code is 4'b1111, so a first valid code of 4'hF starts no pulse and a first valid code of 4'h0 does.
- R2: A falling edge on `awake_n_i` (old sampled level 1, new level 0) sets `awake_irq_o` on the third rising clock edge after the pin changes, because the pin passes through two synchronizer flops. The flag stays set until a one-cycle `irq_clear_i`. If a set and a clear fall in the same cycle, the set wins.
- R3: With `cfg_wd_src_i` = 0, a reset pulse starts when a falling edge is detected on the awake pin. It also starts on the clock edge that accepts a valid code differing from the stored code.
- R4: With `cfg_wd_src_i` = 1, awake edges and code changes start no reset pulse, and only a watchdog expiry does. Awake edges still set `awake_irq_o`.
- R5: `wd_status_o` is set by every watchdog expiry, in either mode. Only `rst_n` clears it. A service strobe, an interrupt clear, a reset pulse or a mode change leaves it set.
- R6: `rst_pulse_o` is high for exactly PULSE_W consecutive cycles after a trigger. A new trigger during an active pulse restarts the full count.
- R7: The watchdog expires on the WD_PERIOD-th rising edge after the last edge that sampled `wd_service_i` high. While the service strobe is held high it never expires. After an expiry it reloads and expires again WD_PERIOD edges later if it is not serviced.
- R8: A rising edge or a steady level on the awake pin does not set the interrupt flag or start a pulse. A valid code equal to the stored code starts no pulse. Code bits are ignored while `ci_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| awake_n_i | input | 1 | Awake request pin, active low, asynchronous |
| ci_code_i | input | 4 | Received command/indication code |
| ci_valid_i | input | 1 | One-cycle strobe marking a new code |
| wd_service_i | input | 1 | Watchdog service strobe |
| cfg_wd_src_i | input | 1 | Reset source select: 0 = awake events, 1 = watchdog |
| irq_clear_i | input | 1 | One-cycle clear of the awake interrupt flag |
| rst_pulse_o | output | 1 | Reset pulse, active high |
| awake_irq_o | output | 1 | Sticky awake interrupt flag |
| wd_status_o | output | 1 | Sticky watchdog-expired flag |

## Verification
Each result has a fixed latency:
- A pin falling edge driven before a rising edge shows on the interrupt flag and the pulse after the third rising edge.
- A code change shows on the pulse after the same edge that accepts it.
- A watchdog expiry shows WD_PERIOD edges after the last service edge. It is absent one edge earlier.

The bench drives every input on the falling clock edge and samples on a later falling edge, counted exactly to those latencies. Each pulse is measured by counting consecutive high samples. The code sweep covers all 256 pairs of old and new code in both modes.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int CI_W = 4;
  typedef logic [CI_W-1:0] ci_code_t;
  localparam ci_code_t CI_RESET = '1;
endpackage

// File: rtl/awr_sync_edge.sv
module awr_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[LAST-1:0], pin_n};
  end

  // falling edge: older synchronized level 1, newer level 0
  assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];

  a_r8_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !sh_q[LAST]);
endmodule

// File: rtl/awr_code_watch.sv
module awr_code_watch
  import awr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ci_code_t code_i,
  input  logic     valid_i,
  output logic     chg_o
);
  ci_code_t last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= CI_RESET;
    else if (valid_i) last_q <= code_i;
  end

  assign chg_o = valid_i && (code_i != last_q);

  a_r8_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(last_q));
endmodule

// File: rtl/awr_watchdog.sv
module awr_watchdog #(
  parameter int WD_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic service_i,
  output logic expire_o,
  output logic status_o
);
  localparam int WDW = (WD_PERIOD > 1) ? $clog2(WD_PERIOD) : 1;
  localparam logic [WDW-1:0] RELOAD = WDW'(WD_PERIOD - 1);

  logic [WDW-1:0] cnt_q;

  assign expire_o = (cnt_q == '0) && !service_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (service_i || cnt_q == '0) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_o <= 1'b0;
    else if (expire_o) status_o <= 1'b1;
  end

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_o |=> status_o);
  a_r7_service_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (service_i && WD_PERIOD > 1) |=> !expire_o);
endmodule

// File: rtl/awr_pulse.sv
module awr_pulse #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_W + 1);
  localparam logic [PW-1:0] FULL = PW'(PULSE_W);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig_i)       cnt_q <= FULL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  a_r6_rise_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(trig_i));
  a_r6_retrigger_holds: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
endmodule

// File: rtl/awake_rst_gen.sv
module awake_rst_gen
  import awr_pkg::*;
#(
  parameter int PULSE_W     = 4,
  parameter int WD_PERIOD   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       awake_n_i,
  input  logic [3:0] ci_code_i,
  input  logic       ci_valid_i,
  input  logic       wd_service_i,
  input  logic       cfg_wd_src_i,
  input  logic       irq_clear_i,
  output logic       rst_pulse_o,
  output logic       awake_irq_o,
  output logic       wd_status_o
);
  logic awake_fall;
  logic code_chg;
  logic wd_expire;
  logic trig;

  awr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(awake_n_i), .fall_o(awake_fall));

  awr_code_watch u_code (
    .clk(clk), .rst_n(rst_n), .code_i(ci_code_t'(ci_code_i)),
    .valid_i(ci_valid_i), .chg_o(code_chg));

  awr_watchdog #(.WD_PERIOD(WD_PERIOD)) u_wd (
    .clk(clk), .rst_n(rst_n), .service_i(wd_service_i),
    .expire_o(wd_expire), .status_o(wd_status_o));

  // source select: watchdog only, or awake events only
  assign trig = cfg_wd_src_i ? wd_expire : (awake_fall | code_chg);

  awr_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(rst_pulse_o));

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           awake_irq_o <= 1'b0;
    else if (awake_fall)  awake_irq_o <= 1'b1;
    else if (irq_clear_i) awake_irq_o <= 1'b0;
  end

  a_r2_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    awake_fall |=> awake_irq_o);
  a_r3_code_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wd_src_i && code_chg) |=> rst_pulse_o);
  a_r4_quiet_in_wd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wd_src_i && !wd_expire && !rst_pulse_o) |=> !rst_pulse_o);
  a_r5_expire_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> wd_status_o);
endmodule

// File: tb/sim_awake_rst_gen.sv
module sim_awake_rst_gen;
  localparam int PW = 4;
  localparam int WP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake_n = 1'b1;
  logic [3:0] code = 4'h0;
  logic valid = 1'b0;
  logic svc = 1'b0;
  logic cfg = 1'b0;
  logic clr = 1'b0;
  logic pulse, irq, status;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  awake_rst_gen #(.PULSE_W(PW), .WD_PERIOD(WP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .awake_n_i(awake_n), .ci_code_i(code),
    .ci_valid_i(valid), .wd_service_i(svc), .cfg_wd_src_i(cfg),
    .irq_clear_i(clr), .rst_pulse_o(pulse), .awake_irq_o(irq),
    .wd_status_o(status));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called on the first high sample; counts consecutive high samples
  task automatic pulse_len(output int n);
    n = 0;
    while (pulse && n < 60) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [3:0] c);
    code = c; valid = 1'b1;
    step(1);
    valid = 1'b0; code = ~c;
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    step(2);
    chk("R1 pulse in reset", pulse, 0);
    chk("R1 irq in reset", irq, 0);
    chk("R5 status cleared by hw reset", status, 0);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 pulse after reset", pulse, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 status after reset", status, 0);
    send(4'hF);
    chk("R1 stored code F no pulse", pulse, 0);
    send(4'h0);
    chk("R1 code 0 differs from reset F", pulse, 1);
    step(8);

    // R3/R8 code sweep, awake mode
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        send(4'(p));
        step(PW + 2);
        send(4'(q));
        chk((q != p) ? "R3 code change pulse" : "R8 equal code no pulse",
            pulse, (q != p) ? 1 : 0);
        step(PW + 2);
      end
    end

    // R8 code bits ignored without valid
    code = 4'hA; step(3); code = 4'h5; step(3);
    chk("R8 code without valid ignored", pulse, 0);
    send(4'hF);
    chk("R8 stored code unchanged by invalid bits", pulse, 0);

    // R2/R3/R6 awake falling edge
    awake_n = 1'b0;
    step(2);
    chk("R2 irq not before third edge", irq, 0);
    step(1);
    chk("R2 irq set after fall", irq, 1);
    chk("R3 fall starts pulse", pulse, 1);
    pulse_len(n);
    chk("R6 pulse width", n, PW);
    step(5);
    chk("R2 irq stays set", irq, 1);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R2 irq cleared", irq, 0);

    // R8 rising edge and steady level
    awake_n = 1'b1;
    step(6);
    chk("R8 rising edge no irq", irq, 0);
    chk("R8 rising edge no pulse", pulse, 0);

    // R2 set beats clear
    awake_n = 1'b0;
    step(2);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R2 set wins over clear", irq, 1);
    step(8);
    clr = 1'b1; step(1); clr = 1'b0;
    awake_n = 1'b1; step(4);

    // R6 retrigger: two changes two cycles apart
    send(4'h3);
    chk("R6 first trigger", pulse, 1);
    step(1);
    send(4'h6);
    pulse_len(n);
    chk("R6 retrigger restarts count", n, PW);
    step(4);

    // R4 watchdog mode: awake events give no pulse
    hw_reset();
    cfg = 1'b1; svc = 1'b1;
    step(2);
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        send(4'(p));
        send(4'(q));
        chk("R4 code change no pulse", pulse, 0);
      end
    end
    awake_n = 1'b0;
    step(3);
    chk("R4 irq still set in wd mode", irq, 1);
    chk("R4 fall no pulse in wd mode", pulse, 0);
    awake_n = 1'b1;
    step(40);
    chk("R7 held service no expiry", status, 0);
    chk("R4 no pulse with service", pulse, 0);

    // R7/R5 expiry timing and auto reload
    svc = 1'b0;
    step(15);
    chk("R7 no expiry one edge early", pulse, 0);
    chk("R5 status still clear", status, 0);
    step(1);
    chk("R7 expiry pulse", pulse, 1);
    chk("R5 status set on expiry", status, 1);
    step(15);
    chk("R7 reload no early expiry", pulse, 0);
    step(1);
    chk("R7 auto reload expiry", pulse, 1);
    svc = 1'b1;

    // R5 status survives everything but hw reset
    clr = 1'b1; step(2); clr = 1'b0;
    cfg = 1'b0;
    send(4'h9);
    step(10);
    chk("R5 status survives strobes and pulse", status, 1);
    svc = 1'b0;
    step(3 * WP);
    chk("R5 expiry in awake mode sets status", status, 1);
    hw_reset();
    chk("R5 status clear after hw reset", status, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule